// File: doc/BRIEF.md
# Daisy-Chain Control Word Forwarder

This block sits in one channel of a chain of serially addressed channels. Each channel takes its serial input from the previous channel's pass-through output. During a chip-select frame the block re-emits every incoming bit on its pass-through output. While the control byte passes, it rewrites the 4-bit channel-ID field so that the next channel receives a value one lower. A host therefore picks a channel by its distance down the chain, not by a strapped address. Two channels in one device link the same way, and each one gets its own ID.

The whole block runs on a single system clock. SCLK, chip select and serial data are sampled as plain synchronous inputs. Bits are taken on a rising SCLK edge and forwarded on the next falling edge. Subtraction works one bit at a time with a borrow flag, so no ID register or adder is needed. The block also raises a target flag at the end of the control byte. The flag is set when the ID received here was zero or when the broadcast bit was set. It holds until chip select goes high.

Top module: `chain_ctrl_fwd`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `thru_o` and `target_o` are 0.
- R2: Line positions of the control byte, in arrival order starting at 0: 0 broadcast, 1 read/write, 2 register/RAM select, 3 reserved. These four bits are forwarded unchanged.
- R3: Line positions 4 to 7 carry the channel ID, least significant bit first. When broadcast is 0, the forwarded ID equals the received ID minus one, modulo 16.
- R4: A received ID of 0 (with broadcast 0) is forwarded as 15, the all-ones value.
- R5: When broadcast is 1, all eight control bits, the ID included, are forwarded unchanged.
- R6: `target_o` goes to 1 when the received ID is 0, and to 0 for any other ID when broadcast is 0.
- R7: When broadcast is 1, `target_o` goes to 1 whatever the ID.
- R8: `target_o` stays 0 until the rising SCLK edge of control bit 7 and takes its value on that edge. It is held while `cs_n` stays low and is cleared while `cs_n` is high.
- R9: Every bit after the control byte (address, data, any further bits) is forwarded unchanged until `cs_n` goes high.
- R10: A bit sampled on a rising SCLK edge appears on `thru_o` after the next falling edge. `thru_o` changes only on falling SCLK edges, so the next channel sees the stream delayed by one SCLK period.
- R11: Raising `cs_n` returns the bit position to 0. A frame cut off in the middle does not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the previous channel or the host |
| thru_o | output | 1 | Pass-through serial data to the next channel |
| target_o | output | 1 | This channel is addressed by the current frame |

## Verification
The bench targets the borrow chain at its ends:
- ID 1 must become 0.
- ID 0 must wrap to 15.
- ID 15 must become 14.
- ID 8 needs a borrow to ripple through three zero bits.

A design that stops the borrow early, or applies it after a one bit, produces the wrong ID for the next channel. Broadcast frames with IDs 0 and 3 show whether the design wrongly decrements when broadcast is set, or fails to assert the target. The bench reads the target flag just before and just after the last control bit, then again after chip select rises. A design that latches too early or never clears the flag leaves a stale select on the next frame. A frame aborted after three bits catches a bit counter that does not restart on chip select.

// File: rtl/chain_fwd_pkg.sv
package chain_fwd_pkg;
  typedef enum logic [1:0] {
    PH_BCAST   = 2'd0,
    PH_HDR     = 2'd1,
    PH_ID      = 2'd2,
    PH_PAYLOAD = 2'd3
  } field_phase_t;
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/ctrl_bit_tracker.sv
module ctrl_bit_tracker
  import chain_fwd_pkg::*;
#(
  parameter int CTRL_BITS  = 8,
  parameter int ID_BITS    = 4,
  parameter int ID_LSB_POS = 4,
  parameter int BCAST_POS  = 0,
  parameter int CNT_W      = $clog2(CTRL_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rise,
  output logic [CNT_W-1:0] bit_cnt,
  output field_phase_t     phase,
  output logic             last_ctrl
);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(CTRL_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CTRL_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_BC   = CNT_W'(BCAST_POS);
  localparam logic [CNT_W-1:0] ID_LO    = CNT_W'(ID_LSB_POS);
  localparam logic [CNT_W-1:0] ID_HI    = CNT_W'(ID_LSB_POS + ID_BITS);

  always_ff @(posedge clk) begin
    if (rst || cs_n)                     bit_cnt <= '0;
    else if (rise && bit_cnt != CNT_DONE) bit_cnt <= bit_cnt + 1'b1;
  end

  always_comb begin
    if (bit_cnt == CNT_DONE)                       phase = PH_PAYLOAD;
    else if (bit_cnt == CNT_BC)                    phase = PH_BCAST;
    else if (bit_cnt >= ID_LO && bit_cnt < ID_HI)  phase = PH_ID;
    else                                           phase = PH_HDR;
  end

  assign last_ctrl = (bit_cnt == CNT_LAST);
endmodule

// File: rtl/id_borrow_chain.sv
module id_borrow_chain
  import chain_fwd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rise,
  input  logic         sdi,
  input  field_phase_t phase,
  input  logic         last_ctrl,
  output logic         fwd_bit,
  output logic         target
);
  logic bcast_q;
  logic borrow_q;
  logic bcast_eff;
  logic borrow_nxt;
  logic bit_nxt;

  assign bcast_eff = (phase == PH_BCAST) ? sdi : bcast_q;

  always_comb begin
    borrow_nxt = borrow_q;
    bit_nxt    = sdi;
    if (phase == PH_ID) begin
      borrow_nxt = borrow_q & ~sdi;
      if (!bcast_q) bit_nxt = sdi ^ borrow_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcast_q  <= 1'b0;
      borrow_q <= 1'b1;
      fwd_bit  <= 1'b0;
      target   <= 1'b0;
    end else if (cs_n) begin
      bcast_q  <= 1'b0;
      borrow_q <= 1'b1;
      target   <= 1'b0;
    end else if (rise) begin
      bcast_q  <= bcast_eff;
      borrow_q <= borrow_nxt;
      fwd_bit  <= bit_nxt;
      if (last_ctrl) target <= bcast_eff | borrow_nxt;
    end
  end
endmodule

// File: rtl/chain_ctrl_fwd.sv
module chain_ctrl_fwd
  import chain_fwd_pkg::*;
#(
  parameter int CTRL_BITS  = 8,
  parameter int ID_BITS    = 4,
  parameter int ID_LSB_POS = 4,
  parameter int BCAST_POS  = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic thru_o,
  output logic target_o
);
  localparam int CNT_W = $clog2(CTRL_BITS + 1);

  logic             rise_evt;
  logic             fall_evt;
  logic [CNT_W-1:0] bit_cnt;
  field_phase_t     phase;
  logic             last_ctrl;
  logic             fwd_bit;

  sclk_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .rise (rise_evt),
    .fall (fall_evt)
  );

  ctrl_bit_tracker #(
    .CTRL_BITS  (CTRL_BITS),
    .ID_BITS    (ID_BITS),
    .ID_LSB_POS (ID_LSB_POS),
    .BCAST_POS  (BCAST_POS),
    .CNT_W      (CNT_W)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rise      (rise_evt),
    .bit_cnt   (bit_cnt),
    .phase     (phase),
    .last_ctrl (last_ctrl)
  );

  id_borrow_chain u_borrow (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rise      (rise_evt),
    .sdi       (sdi),
    .phase     (phase),
    .last_ctrl (last_ctrl),
    .fwd_bit   (fwd_bit),
    .target    (target_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           thru_o <= 1'b0;
    else if (fall_evt) thru_o <= fwd_bit;
  end
endmodule

// File: rtl/chain_ctrl_fwd_chk.sv
module chain_ctrl_fwd_chk #(
  parameter int CTRL_BITS = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             fall_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             thru_o,
  input logic             target_o
);
  AST_THRU_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !fall_evt |=> $stable(thru_o));  // R10

  AST_TARGET_CLEARED_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !target_o);  // R8

  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (rst)
    (target_o && !cs_n) |=> target_o);  // R8

  AST_TARGET_AT_CTRL_END: assert property (@(posedge clk) disable iff (rst)
    $rose(target_o) |-> (bit_cnt == CNT_W'(CTRL_BITS)));  // R8

  AST_POS_RESTART: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (bit_cnt == '0));  // R11
endmodule

bind chain_ctrl_fwd chain_ctrl_fwd_chk #(
  .CTRL_BITS (CTRL_BITS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .fall_evt (fall_evt),
  .bit_cnt  (bit_cnt),
  .thru_o   (thru_o),
  .target_o (target_o)
);

// File: tb/test_chain_ctrl_fwd.sv
module test_chain_ctrl_fwd;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 3;
  localparam int NBITS      = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic thru_o;
  logic target_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_ctrl_fwd i_chain_ctrl_fwd (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdi      (sdi),
    .thru_o   (thru_o),
    .target_o (target_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame; line order: bc, rw, rs, rsv, id[0..3], addr msb first, data msb first
  task automatic run_xfer(input logic bc, input logic rw, input logic rs, input logic rsv,
                          input logic [3:0] id, input logic [7:0] addr, input logic [7:0] data,
                          input string tag);
    logic [NBITS-1:0] tx;
    logic [NBITS-1:0] rx;
    logic [3:0] id_out;
    logic exp_tgt;
    tx[0] = bc; tx[1] = rw; tx[2] = rs; tx[3] = rsv;
    for (int i = 0; i < 4; i++) tx[4+i] = id[i];
    for (int i = 0; i < 8; i++) tx[8+i]  = addr[7-i];
    for (int i = 0; i < 8; i++) tx[16+i] = data[7-i];
    exp_tgt = bc | (id == 4'd0);
    rx = '0;
    @(negedge clk); cs_n = 1'b0;
    wait_n(2);
    for (int k = 0; k <= NBITS; k++) begin
      sdi = (k < NBITS) ? tx[k] : 1'b0;
      wait_n(HALF_SCLK);
      if (k > 0) rx[k-1] = thru_o;
      if (k == 7) chk("R8", {tag, " target before last ctrl bit"}, int'(target_o), 0);
      sclk = 1'b1;
      wait_n(HALF_SCLK);
      if (k == 7) chk(bc ? "R7" : "R6", {tag, " target after ctrl byte"}, int'(target_o), int'(exp_tgt));
      sclk = 1'b0;
    end
    wait_n(HALF_SCLK);
    chk("R8", {tag, " target held to frame end"}, int'(target_o), int'(exp_tgt));
    chk("R2", {tag, " header bits"}, int'(rx[3:0]), int'(tx[3:0]));
    for (int i = 0; i < 4; i++) id_out[i] = rx[4+i];
    if (bc)            chk("R5", {tag, " id under broadcast"}, int'(id_out), int'(id));
    else if (id == 0)  chk("R4", {tag, " id wrap"}, int'(id_out), 15);
    else               chk("R3", {tag, " id decrement"}, int'(id_out), int'(id - 4'd1));
    chk("R9", {tag, " address and data"}, int'(rx[23:8]), int'(tx[23:8]));
    cs_n = 1'b1;
    wait_n(2);
    chk("R8", {tag, " target cleared after cs_n"}, int'(target_o), 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_n(3);
    chk("R1", "thru in reset", int'(thru_o), 0);
    chk("R1", "target in reset", int'(target_o), 0);
    rst = 1'b0;
    wait_n(1);
    chk("R1", "thru after reset", int'(thru_o), 0);
    chk("R1", "target after reset", int'(target_o), 0);
  endtask

  task automatic t_latency;
    // R10: bit sampled at a rise shows only after the following fall
    @(negedge clk); cs_n = 1'b0; sdi = 1'b1;
    wait_n(HALF_SCLK);
    sclk = 1'b1;
    wait_n(HALF_SCLK);
    chk("R10", "thru before fall", int'(thru_o), 0);
    sclk = 1'b0;
    wait_n(HALF_SCLK);
    chk("R10", "thru after fall", int'(thru_o), 1);
    cs_n = 1'b1;
    wait_n(2);
  endtask

  task automatic t_abort;
    // R11: three bits then cs_n high; next frame decodes from position 0
    @(negedge clk); cs_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      sdi = 1'b1;
      wait_n(HALF_SCLK); sclk = 1'b1;
      wait_n(HALF_SCLK); sclk = 1'b0;
    end
    wait_n(HALF_SCLK);
    cs_n = 1'b1;
    wait_n(2);
    run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 8'h3C, 8'h81, "R11 after abort");
  endtask

  initial begin
    t_reset();
    t_latency();
    run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  8'hA5, 8'h5A, "id0");
    run_xfer(1'b0, 1'b1, 1'b1, 1'b0, 4'd1,  8'h01, 8'hFF, "id1");
    run_xfer(1'b0, 1'b0, 1'b1, 1'b1, 4'd5,  8'hC3, 8'h00, "id5");
    run_xfer(1'b0, 1'b1, 1'b0, 1'b1, 4'd8,  8'h7E, 8'h99, "id8");
    run_xfer(1'b0, 1'b1, 1'b1, 1'b1, 4'd15, 8'hFF, 8'h12, "id15");
    run_xfer(1'b1, 1'b0, 1'b1, 1'b0, 4'd3,  8'h44, 8'hE7, "bcast id3");
    run_xfer(1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  8'h10, 8'h08, "bcast id0");
    t_abort();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule